// File: doc/BRIEF.md
# EEPROM Lower-Half Write-Protect Controller

This block decides, byte by byte, how a serial-presence-detect EEPROM answers on its two-wire bus when write protection is involved. A bit-level I2C slave engine in front of it turns the wire traffic into decoded byte events: a device-select byte (after START or repeated START), the word-address byte, data bytes, and STOP. For every byte event the block returns one ACK/NACK decision. At the STOP that closes an accepted write, it raises a one-cycle pulse that starts the internal write cycle.

The block keeps a protection level for bytes 0..127 of the 256-byte array. The level is unprotected, reversibly locked or permanently locked. Protection instructions share their own device code. The set-lock and clear-lock forms are told apart by the A2/A1 select bits while a high-voltage level is present on pin A0. The permanent form is sent with normal pin levels. The permanent level is mirrored by an external non-volatile bit: the block pulses a program request for it and reads it back as an input. Once that bit is set, the protection device code is refused outright.

Byte events enter on a valid/ready channel and decisions leave on a valid/ready channel. There is one decision register, so an event is taken only while that register is empty or is being drained in the same cycle. A held decision stays unchanged until the consumer takes it.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: A device-select byte is laid out as bits [7:4] device code, [3:1] pins A2,A1,A0 and [0] R/W (1 = read). Code 1010 selects the memory only when the pin bits equal `strap`. Any other code is NACKed, and every later byte up to STOP is NACKed with no write pulse.
- R2: With no protection set, each of the three protection instructions (code 0110, R/W = 0) is ACKed on the device-select, address and data bytes. At STOP it commits: permanent goes to the permanent level, set-lock goes to reversible, and clear-lock goes to unprotected.
- R3: With `hv_a0` = 1 on the device-select byte, A2A1 = 00 means set-lock, A2A1 = 01 means clear-lock, and A2 = 1 is NACKed. With `hv_a0` = 0, code 0110 with R/W = 0 means permanent-lock only when the pin bits equal `strap`.
- R4: Under the reversible level, a repeated set-lock is NACKed on every byte and commits nothing. Clear-lock and permanent-lock are ACKed and commit.
- R5: At the permanent level (set by commit, or by `perm_nv_in` = 1), every device-select byte with code 0110 is NACKed and the level never changes. A committed permanent-lock pulses `perm_prog` together with `wr_start`.
- R6: While protection is set, a memory write whose address byte has bit 7 = 0 gets ACK on the device-select and address bytes and NACK on data, and no write pulse at STOP.
- R7: A memory write to address bit 7 = 1, or to any address while unprotected, is ACKed on all bytes, including several page data bytes, and pulses `wr_start` at STOP.
- R8: A status read (code 0110, R/W = 1, pins equal to `strap`, `hv_a0` = 0) is ACKed on the device-select byte only when unprotected. Memory reads are ACKed on the device-select byte. Later bytes of any read are NACKed, and reads never pulse `wr_start`.
- R9: A commit happens only at a STOP that follows an accepted data byte. A STOP before that, or a device-select byte (repeated START) arriving first, drops the instruction with no pulse and no level change.
- R10: A second data byte inside a protection instruction is NACKed and the instruction is dropped.
- R11: `wr_start` is high for exactly the cycle after the STOP event is taken. While `cyc_busy` = 1, every device-select byte is NACKed.
- R12: Event kinds on `ev_kind` are 0 device-select, 1 address, 2 data and 3 STOP. `ev_ready` = !`rsp_valid` or `rsp_ready`. Each taken non-STOP event yields one decision in the next cycle, and STOP yields none. A decision is held stable while `rsp_ready` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Byte event present |
| ev_ready | output | 1 | Byte event taken this cycle if valid |
| ev_kind | input | 2 | 0 device-select, 1 address, 2 data, 3 STOP |
| ev_byte | input | 8 | Byte value of the event |
| hv_a0 | input | 1 | High-voltage level present on pin A0 |
| strap | input | 3 | Board levels of pins A2,A1,A0 |
| cyc_busy | input | 1 | Internal write cycle in progress |
| perm_nv_in | input | 1 | Non-volatile permanent-lock bit read back |
| rsp_valid | output | 1 | ACK/NACK decision present |
| rsp_ready | input | 1 | Consumer takes the decision |
| rsp_ack | output | 1 | 1 = ACK, 0 = NACK |
| wr_start | output | 1 | One-cycle pulse starting the write cycle |
| perm_prog | output | 1 | One-cycle request to program the non-volatile bit |

## Verification
The main function is driven through every protection instruction from each of the three levels, so the bench can separate a decision that depends on the command alone from one that depends on the level as well. Memory writes to both halves at each level show whether the lock follows address bit 7 and the current level, and a page write checks that acceptance carries across several data bytes. Truncated instructions cover an early STOP, a repeated START and an extra data byte, and show that commits happen only at a legitimate STOP. Stalls on the decision channel and a busy write cycle test the back-pressure and refusal rules, and a reset with the non-volatile bit set shows that the permanent level comes back.

// File: rtl/eeprom_wp_pkg.sv
package eeprom_wp_pkg;

  typedef enum logic [1:0] {
    EV_DEVSEL = 2'd0,
    EV_ADDR   = 2'd1,
    EV_DATA   = 2'd2,
    EV_STOP   = 2'd3
  } ev_kind_t;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_MEM_WR,
    CMD_MEM_RD,
    CMD_PERM,
    CMD_SET_REV,
    CMD_CLR_REV,
    CMD_STAT_RD,
    CMD_BAD
  } cmd_t;

  typedef enum logic [1:0] {
    PS_NONE = 2'd0,
    PS_REV  = 2'd1,
    PS_PERM = 2'd2
  } prot_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_ARMED,
    PH_REJ
  } phase_t;

  function automatic logic is_prot_family(cmd_t c);
    return (c == CMD_PERM) || (c == CMD_SET_REV) || (c == CMD_CLR_REV) ||
           (c == CMD_STAT_RD) || (c == CMD_BAD);
  endfunction

endpackage

// File: rtl/wp_devsel_decode.sv
module wp_devsel_decode
  import eeprom_wp_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int PIN_W  = 3,
  parameter logic [CODE_W-1:0] MEM_CODE  = 4'b1010,
  parameter logic [CODE_W-1:0] PROT_CODE = 4'b0110,
  localparam int BYTE_W = CODE_W + PIN_W + 1
) (
  input  logic [BYTE_W-1:0] dev_byte,
  input  logic              hv_a0,
  input  logic [PIN_W-1:0]  strap,
  output cmd_t              cmd
);

  logic [CODE_W-1:0] code;
  logic [PIN_W-1:0]  pins;
  logic              rd;
  logic [1:0]        hv_sel;

  assign code   = dev_byte[BYTE_W-1 -: CODE_W];
  assign pins   = dev_byte[PIN_W:1];
  assign rd     = dev_byte[0];
  assign hv_sel = pins[PIN_W-1 -: 2];

  always_comb begin
    cmd = CMD_NONE;
    if (code == MEM_CODE) begin
      if (pins == strap) cmd = rd ? CMD_MEM_RD : CMD_MEM_WR;
    end else if (code == PROT_CODE) begin
      if (rd) begin
        cmd = (pins == strap && !hv_a0) ? CMD_STAT_RD : CMD_BAD;
      end else if (hv_a0) begin
        case (hv_sel)
          2'b00:   cmd = CMD_SET_REV;
          2'b01:   cmd = CMD_CLR_REV;
          default: cmd = CMD_BAD;
        endcase
      end else begin
        cmd = (pins == strap) ? CMD_PERM : CMD_BAD;
      end
    end
  end

endmodule

// File: rtl/wp_prot_state.sv
module wp_prot_state
  import eeprom_wp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  perm_nv_in,
  input  logic  commit,
  input  cmd_t  commit_cmd,
  output prot_t level,
  output logic  perm_prog
);

  prot_t level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q   <= PS_NONE;
      perm_prog <= 1'b0;
    end else begin
      perm_prog <= commit && (commit_cmd == CMD_PERM);
      if (commit && level != PS_PERM) begin
        case (commit_cmd)
          CMD_PERM:    level_q <= PS_PERM;
          CMD_SET_REV: level_q <= PS_REV;
          CMD_CLR_REV: level_q <= PS_NONE;
          default:     level_q <= level_q;
        endcase
      end
    end
  end

  assign level = perm_nv_in ? PS_PERM : level_q;

  p_perm_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    level_q == PS_PERM |=> level_q == PS_PERM);

endmodule

// File: rtl/wp_txn.sv
module wp_txn
  import eeprom_wp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ev_fire,
  input  ev_kind_t kind,
  input  logic     addr_msb,
  input  cmd_t     cmd,
  input  prot_t    level,
  input  logic     cyc_busy,
  input  logic     rsp_ready,
  output logic     rsp_valid,
  output logic     rsp_ack,
  output logic     wr_start,
  output logic     commit,
  output cmd_t     commit_cmd
);

  phase_t phase_q, phase_d;
  cmd_t   cmd_q, cmd_d;
  logic   hi_q, hi_d;
  logic   give_rsp, ack_d;

  always_comb begin
    phase_d  = phase_q;
    cmd_d    = cmd_q;
    hi_d     = hi_q;
    give_rsp = 1'b0;
    ack_d    = 1'b0;
    commit   = 1'b0;
    if (ev_fire) begin
      case (kind)
        EV_DEVSEL: begin
          give_rsp = 1'b1;
          cmd_d    = cmd;
          phase_d  = PH_REJ;
          if (!cyc_busy) begin
            case (cmd)
              CMD_MEM_WR: begin ack_d = 1'b1; phase_d = PH_ADDR; end
              CMD_MEM_RD: ack_d = 1'b1;
              CMD_STAT_RD: ack_d = (level == PS_NONE);
              CMD_PERM, CMD_CLR_REV: begin
                if (level != PS_PERM) begin ack_d = 1'b1; phase_d = PH_ADDR; end
              end
              CMD_SET_REV: begin
                if (level == PS_NONE) begin ack_d = 1'b1; phase_d = PH_ADDR; end
              end
              default: ack_d = 1'b0;
            endcase
          end
        end
        EV_ADDR: begin
          give_rsp = 1'b1;
          if (phase_q == PH_ADDR) begin
            ack_d   = 1'b1;
            hi_d    = addr_msb;
            phase_d = PH_DATA;
          end else begin
            phase_d = PH_REJ;
          end
        end
        EV_DATA: begin
          give_rsp = 1'b1;
          phase_d  = PH_REJ;
          if (cmd_q == CMD_MEM_WR && (phase_q == PH_DATA || phase_q == PH_ARMED)) begin
            if (level == PS_NONE || hi_q) begin
              ack_d   = 1'b1;
              phase_d = PH_ARMED;
            end
          end else if (cmd_q != CMD_MEM_WR && phase_q == PH_DATA) begin
            ack_d   = 1'b1;
            phase_d = PH_ARMED;
          end
        end
        default: begin
          commit  = (phase_q == PH_ARMED);
          phase_d = PH_IDLE;
        end
      endcase
    end
  end

  assign commit_cmd = cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cmd_q     <= CMD_NONE;
      hi_q      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
      wr_start  <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cmd_q    <= cmd_d;
      hi_q     <= hi_d;
      wr_start <= commit;
      if (give_rsp) begin
        rsp_valid <= 1'b1;
        rsp_ack   <= ack_d;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  p_wr_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !wr_start);

  p_busy_nack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire && kind == EV_DEVSEL && cyc_busy |=> rsp_valid && !rsp_ack);

  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready && !ev_fire |=> rsp_valid && $stable(rsp_ack));

  p_perm_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire && kind == EV_DEVSEL && level == PS_PERM && is_prot_family(cmd)
    |=> !rsp_ack);

  p_low_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire && kind == EV_DATA && cmd_q == CMD_MEM_WR && level != PS_NONE && !hi_q
    |=> !rsp_ack);

endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
  import eeprom_wp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CODE_W = 4,
  parameter int PIN_W  = 3,
  localparam int BYTE_W = CODE_W + PIN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [1:0]        ev_kind,
  input  logic [BYTE_W-1:0] ev_byte,
  input  logic              hv_a0,
  input  logic [PIN_W-1:0]  strap,
  input  logic              cyc_busy,
  input  logic              perm_nv_in,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_ack,
  output logic              wr_start,
  output logic              perm_prog
);

  cmd_t  dec_cmd, commit_cmd;
  prot_t level;
  logic  ev_fire, commit;

  assign ev_ready = !rsp_valid || rsp_ready;
  assign ev_fire  = ev_valid && ev_ready;

  wp_devsel_decode #(.CODE_W(CODE_W), .PIN_W(PIN_W)) u_dec (
    .dev_byte (ev_byte),
    .hv_a0    (hv_a0),
    .strap    (strap),
    .cmd      (dec_cmd)
  );

  wp_prot_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .perm_nv_in (perm_nv_in),
    .commit     (commit),
    .commit_cmd (commit_cmd),
    .level      (level),
    .perm_prog  (perm_prog)
  );

  wp_txn u_txn (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_fire    (ev_fire),
    .kind       (ev_kind_t'(ev_kind)),
    .addr_msb   (ev_byte[ADDR_W-1]),
    .cmd        (dec_cmd),
    .level      (level),
    .cyc_busy   (cyc_busy),
    .rsp_ready  (rsp_ready),
    .rsp_valid  (rsp_valid),
    .rsp_ack    (rsp_ack),
    .wr_start   (wr_start),
    .commit     (commit),
    .commit_cmd (commit_cmd)
  );

  p_prog_with_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    perm_prog |-> wr_start);

endmodule

// File: tb/eeprom_wp_ctrl_tb_top.sv
module eeprom_wp_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_valid = 1'b0;
  logic       ev_ready;
  logic [1:0] ev_kind = 2'd0;
  logic [7:0] ev_byte = 8'h00;
  logic       hv_a0 = 1'b0;
  logic [2:0] strap = 3'b010;
  logic       cyc_busy = 1'b0;
  logic       perm_nv_in = 1'b0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic       rsp_ack;
  logic       wr_start;
  logic       perm_prog;

  int total = 0;
  int bad = 0;
  string cur_req = "R12";
  logic nv_clear = 1'b0;

  always #4 clk = ~clk;

  eeprom_wp_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_byte(ev_byte), .hv_a0(hv_a0), .strap(strap),
    .cyc_busy(cyc_busy), .perm_nv_in(perm_nv_in), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_ack(rsp_ack), .wr_start(wr_start),
    .perm_prog(perm_prog)
  );

  // emulated non-volatile bit: programmed by perm_prog, wiped only by the bench
  always @(posedge clk) begin
    if (nv_clear) perm_nv_in <= 1'b0;
    else if (perm_prog) perm_nv_in <= 1'b1;
  end

  // ---------------- behavioural reference ----------------
  int m_level, m_phase, m_cmd;
  bit m_hi, e_rv, e_ack, e_wr, e_pp;

  function automatic int ref_decode(logic [7:0] b, logic hv, logic [2:0] s);
    // 0 none 1 memwr 2 memrd 3 perm 4 setrev 5 clrrev 6 status 7 refused
    if (b[7:4] == 4'b1010) return (b[3:1] == s) ? (b[0] ? 2 : 1) : 0;
    if (b[7:4] != 4'b0110) return 0;
    if (b[0]) return (b[3:1] == s && !hv) ? 6 : 7;
    if (hv) return (b[3:2] == 2'b00) ? 4 : (b[3:2] == 2'b01) ? 5 : 7;
    return (b[3:1] == s) ? 3 : 7;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_level = 0; m_phase = 0; m_cmd = 0; m_hi = 0;
      e_rv = 0; e_ack = 0; e_wr = 0; e_pp = 0;
    end else begin
      automatic bit fire = ev_valid && (!e_rv || rsp_ready);
      automatic int lvl = perm_nv_in ? 2 : m_level;
      e_wr = 0; e_pp = 0;
      if (e_rv && rsp_ready) e_rv = 0;
      if (fire) begin
        if (ev_kind == 2'd3) begin
          if (m_phase == 3) begin
            e_wr = 1;
            if (lvl != 2) begin
              if (m_cmd == 3) begin m_level = 2; e_pp = 1; end
              else if (m_cmd == 4) m_level = 1;
              else if (m_cmd == 5) m_level = 0;
            end
          end
          m_phase = 0;
        end else begin
          e_rv = 1; e_ack = 0;
          if (ev_kind == 2'd0) begin
            automatic int c = ref_decode(ev_byte, hv_a0, strap);
            m_cmd = c; m_phase = 4;
            if (!cyc_busy) begin
              if (c == 1) begin e_ack = 1; m_phase = 1; end
              else if (c == 2) e_ack = 1;
              else if (c == 6) e_ack = (lvl == 0);
              else if ((c == 3 || c == 5) && lvl != 2) begin e_ack = 1; m_phase = 1; end
              else if (c == 4 && lvl == 0) begin e_ack = 1; m_phase = 1; end
            end
          end else if (ev_kind == 2'd1) begin
            if (m_phase == 1) begin e_ack = 1; m_hi = ev_byte[7]; m_phase = 2; end
            else m_phase = 4;
          end else begin
            if (m_cmd == 1 && (m_phase == 2 || m_phase == 3)) begin
              if (lvl == 0 || m_hi) begin e_ack = 1; m_phase = 3; end
              else m_phase = 4;
            end else if (m_cmd != 1 && m_phase == 2) begin
              e_ack = 1; m_phase = 3;
            end else m_phase = 4;
          end
        end
      end
    end
  end

  task automatic chk(bit got, bit exp, string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      chk(ev_ready, !e_rv || rsp_ready, "ev_ready");
      chk(rsp_valid, e_rv, "rsp_valid");
      if (e_rv) chk(rsp_ack, e_ack, "rsp_ack");
      chk(wr_start, e_wr, "wr_start");
      chk(perm_prog, e_pp, "perm_prog");
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(int kind, logic [7:0] b);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = kind[1:0]; ev_byte = b;
    #1;
    while (!ev_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  function automatic logic [7:0] dsel(logic [3:0] code, logic [2:0] pins, logic rw);
    return {code, pins, rw};
  endfunction

  task automatic mem_wr(logic [7:0] a, int n);
    send(0, dsel(4'b1010, 3'b010, 1'b0));
    send(1, a);
    for (int i = 0; i < n; i++) send(2, 8'h5A + i[7:0]);
    send(3, 8'h00);
  endtask

  task automatic prot(logic [2:0] pins, logic hv, int ndata);
    hv_a0 = hv;
    send(0, dsel(4'b0110, pins, 1'b0));
    hv_a0 = 1'b0;
    send(1, 8'hFF);
    for (int i = 0; i < ndata; i++) send(2, 8'h00);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        while (wd < 20000) begin @(posedge clk); wd++; end
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    cur_req = "R12";
    chk(rsp_valid, 1'b0, "reset rsp_valid");
    chk(wr_start, 1'b0, "reset wr_start");
    chk(perm_prog, 1'b0, "reset perm_prog");
    rst_n = 1'b1;

    cur_req = "R1";
    send(0, dsel(4'b0011, 3'b010, 1'b0)); send(1, 8'h00); send(2, 8'h11); send(3, 8'h00);
    send(0, dsel(4'b1010, 3'b011, 1'b0)); send(1, 8'h00); send(3, 8'h00);

    cur_req = "R7";
    mem_wr(8'h90, 3);
    mem_wr(8'h10, 1);

    cur_req = "R8";
    send(0, dsel(4'b0110, 3'b010, 1'b1)); send(2, 8'h00); send(3, 8'h00);
    send(0, dsel(4'b1010, 3'b010, 1'b1)); send(2, 8'h00); send(3, 8'h00);

    cur_req = "R2";
    prot(3'b001, 1'b1, 1); send(3, 8'h00);

    cur_req = "R6";
    mem_wr(8'h05, 1);
    cur_req = "R7";
    mem_wr(8'hF0, 2);

    cur_req = "R4";
    prot(3'b000, 1'b1, 1); send(3, 8'h00);
    cur_req = "R8";
    send(0, dsel(4'b0110, 3'b010, 1'b1)); send(3, 8'h00);

    cur_req = "R3";
    prot(3'b100, 1'b1, 1); send(3, 8'h00);
    prot(3'b110, 1'b0, 1); send(3, 8'h00);

    cur_req = "R9";
    prot(3'b010, 1'b1, 0); send(3, 8'h00);
    prot(3'b010, 1'b1, 1);
    send(0, dsel(4'b1010, 3'b010, 1'b0)); send(1, 8'h20); send(2, 8'h01); send(3, 8'h00);

    cur_req = "R4";
    prot(3'b011, 1'b1, 1); send(3, 8'h00);
    cur_req = "R6";
    mem_wr(8'h20, 1);

    cur_req = "R10";
    prot(3'b000, 1'b1, 2); send(3, 8'h00);
    mem_wr(8'h30, 1);

    cur_req = "R11";
    cyc_busy = 1'b1;
    send(0, dsel(4'b1010, 3'b010, 1'b0)); send(1, 8'h90); send(2, 8'h01); send(3, 8'h00);
    cyc_busy = 1'b0;

    cur_req = "R12";
    rsp_ready = 1'b0;
    fork
      begin send(0, dsel(4'b1010, 3'b010, 1'b0)); send(1, 8'hA0); end
      begin repeat (5) @(negedge clk); rsp_ready = 1'b1; end
    join
    rsp_ready = 1'b0;
    fork
      begin send(2, 8'h33); end
      begin repeat (3) @(negedge clk); rsp_ready = 1'b1; end
    join
    send(3, 8'h00);

    cur_req = "R4";
    prot(3'b000, 1'b1, 1); send(3, 8'h00);
    prot(3'b010, 1'b0, 1); send(3, 8'h00);

    cur_req = "R5";
    prot(3'b011, 1'b1, 1); send(3, 8'h00);
    send(0, dsel(4'b0110, 3'b010, 1'b1)); send(3, 8'h00);
    mem_wr(8'h00, 1);
    mem_wr(8'h80, 1);
    do_reset();
    mem_wr(8'h40, 1);
    prot(3'b010, 1'b0, 1); send(3, 8'h00);

    cur_req = "R2";
    nv_clear = 1'b1;
    do_reset();
    nv_clear = 1'b0;
    mem_wr(8'h40, 1);
    prot(3'b010, 1'b0, 1); send(3, 8'h00);
    cur_req = "R5";
    mem_wr(8'h41, 1);

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule